// File: doc/BRIEF.md
# Sticky Diagnostic Fault Register

This block holds the diagnostic status byte of a motor bridge driver. Fault detectors upstream present a live 2-bit condition code for each bridge output and single-cycle pulses for three thermal and current events. The register latches every fault it sees and keeps it until a defined clear event. All fault bits are active-low: a 1 means nothing has been seen and a 0 means a fault was captured. The top bit is not stored. It shows, live, whether the enable and disable pins together allow the bridge to run.

A serial front end, outside this block, reads the byte. It raises `rd_start` when the response byte begins, which freezes a copy of the visible value into `rd_data`. It raises `rd_commit` when the frame has been accepted, which clears the register. Faults that arrive between those two pulses survive the clear, so a read never loses a fault. Other clears come from the driver pins and from a pulse marking re-entry into serial mode. While undervoltage is present, the four output-code bits read as zero. The captured codes underneath are kept and reappear when the supply recovers.

Top module: `diag_fault_reg`

## Requirements
- R1: After synchronous reset, with EN=1 and DI=0, `diag_q` reads 0xFF and `rd_data` reads 0xFF.
- R2: The layout of `diag_q` is: bit 7 the pin state, bit 6 overtemperature, bit 5 temperature-dependent current reduction, bit 4 current limiting, bits 3:2 the code of output 2, bits 1:0 the code of output 1 (`ch_code[3:2]` and `ch_code[1:0]`).
- R3: A pulse on `ot_evt`, `cur_red_evt` or `cur_lim_evt` drives the matching bit to 0 from the next clock edge. The bit stays 0 until a clear event.
- R4: The output codes are 11 no error, 10 short to ground, 01 short to battery, and 00 short-circuit overload (output 1) or open load (output 2). Each stored code bit becomes 0 one edge after its input bit is 0 and never returns to 1 without a clear. Codes seen at different times therefore merge by bitwise AND, so 01 followed by 10 reads 00.
- R5: On every cycle with DI=1 or EN=0, bits 6:0 are set to all ones at the next edge. Faults presented in such a cycle are discarded.
- R6: Bit 7 of `diag_q` is 1 exactly when EN=1 and DI=0. It follows the pins in the same cycle.
- R7: While `uv`=1, bits 3:0 of `diag_q` read 0000. The stored codes keep capturing, and when `uv` returns to 0 the stored codes show again.
- R8: A pulse on `spi_entry` sets bits 6:0 to all ones at the next edge. Faults presented in that cycle are discarded.
- R9: At the edge that ends a cycle with `rd_start`=1, `rd_data` takes the value `diag_q` showed in that cycle. It holds that value until the next `rd_start`.
- R10: `rd_commit` after a pending `rd_start` clears bits 6:0. The only exceptions are faults presented from the `rd_start` cycle through the commit cycle, which are stored. A commit with no pending read keeps only the faults of the commit cycle.
- R11: Clear priority is pin clear, then `spi_entry`, then `rd_commit`. When any of these coincide, the highest-priority clear decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_code | input | 4 | Live condition codes; output 1 in bits 1:0, output 2 in bits 3:2 |
| cur_lim_evt | input | 1 | Current-limiting event pulse |
| cur_red_evt | input | 1 | Temperature-dependent current reduction pulse |
| ot_evt | input | 1 | Overtemperature event pulse |
| pin_di | input | 1 | Disable pin state (1 = disabled) |
| pin_en | input | 1 | Enable pin state (1 = enabled) |
| uv | input | 1 | Supply undervoltage present |
| spi_entry | input | 1 | Serial-mode re-entry pulse |
| rd_start | input | 1 | Start of the response byte of a read |
| rd_commit | input | 1 | Accepted end of a read access |
| diag_q | output | 8 | Visible register value |
| rd_data | output | 8 | Snapshot taken at `rd_start` |

## Verification
Directed sequences step one event flag at a time and confirm the bit position each one lands on. They then apply two different output codes in turn, so that a bitwise-AND merge can be told apart from last-value capture. Reads are run with a new fault arriving between snapshot and commit, which separates a commit that reloads the post-snapshot faults from one that simply clears. A read is also run during undervoltage, which shows that the mask applies to the visible byte while the stored codes stay intact. Seeded random traffic then mixes pin clears, serial re-entry, undervoltage bursts and overlapping reads against a bench model, exposing priority and same-cycle corner cases.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [1:0] {
        CLR_NONE   = 2'd0,
        CLR_LEVEL  = 2'd1,
        CLR_SPI    = 2'd2,
        CLR_COMMIT = 2'd3
    } clr_kind_e;

    // Pin clear wins over serial re-entry, which wins over read commit.
    function automatic clr_kind_e pick_clear(input logic di, input logic en,
                                             input logic spi, input logic commit);
        if (di || !en)
            return CLR_LEVEL;
        else if (spi)
            return CLR_SPI;
        else if (commit)
            return CLR_COMMIT;
        return CLR_NONE;
    endfunction

    // Bridge may run only when enabled and not disabled.
    function automatic logic run_state(input logic di, input logic en);
        return en & ~di;
    endfunction

endpackage

// File: rtl/diag_clear_ctrl.sv
module diag_clear_ctrl
    import diag_pkg::*;
(
    input  logic      pin_di,
    input  logic      pin_en,
    input  logic      spi_entry,
    input  logic      rd_commit,
    output clr_kind_e kind
);

    always_comb begin
        kind = pick_clear(pin_di, pin_en, spi_entry, rd_commit);
    end

endmodule

// File: rtl/diag_sticky_cell.sv
module diag_sticky_cell
    import diag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  clr_kind_e kind,
    input  logic      rd_start,
    input  logic      pend,
    input  logic      use_post,
    input  logic      evt_n,
    output logic      stored_q,
    output logic      post_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= 1'b1;
            post_q   <= 1'b1;
        end else begin
            case (kind)
                CLR_LEVEL, CLR_SPI: begin
                    stored_q <= 1'b1;
                    post_q   <= 1'b1;
                end
                CLR_COMMIT: begin
                    stored_q <= (use_post ? post_q : 1'b1) & evt_n;
                    post_q   <= 1'b1;
                end
                default: begin
                    stored_q <= stored_q & evt_n;
                    if (rd_start)
                        post_q <= evt_n;
                    else if (pend)
                        post_q <= post_q & evt_n;
                end
            endcase
        end
    end

endmodule

// File: rtl/diag_sticky_bank.sv
module diag_sticky_bank
    import diag_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  clr_kind_e    kind,
    input  logic         rd_start,
    input  logic [W-1:0] evt_n,
    output logic [W-1:0] stored_q
);

    logic         pend_q;
    logic         use_post;
    logic [W-1:0] post_q;

    assign use_post = pend_q && !rd_start;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (kind != CLR_NONE)
            pend_q <= 1'b0;
        else if (rd_start)
            pend_q <= 1'b1;
    end

    for (genvar i = 0; i < W; i++) begin : g_cell
        diag_sticky_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .kind     (kind),
            .rd_start (rd_start),
            .pend     (pend_q),
            .use_post (use_post),
            .evt_n    (evt_n[i]),
            .stored_q (stored_q[i]),
            .post_q   (post_q[i])
        );
    end

    // R3 R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        kind == CLR_NONE |=> (stored_q & ~$past(stored_q)) == '0);

    // R5
    level_clear_chk: assert property (@(posedge clk) disable iff (rst)
        kind == CLR_LEVEL |=> &stored_q);

    // R10
    commit_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == CLR_COMMIT && !(&evt_n)) |=> !(&stored_q));

    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_start && kind == CLR_NONE) |=> pend_q);

endmodule

// File: rtl/diag_fault_reg.sv
module diag_fault_reg
    import diag_pkg::*;
#(
    parameter int NUM_OUT = 2,
    parameter int CODE_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_OUT*CODE_W-1:0]   ch_code,
    input  logic                        cur_lim_evt,
    input  logic                        cur_red_evt,
    input  logic                        ot_evt,
    input  logic                        pin_di,
    input  logic                        pin_en,
    input  logic                        uv,
    input  logic                        spi_entry,
    input  logic                        rd_start,
    input  logic                        rd_commit,
    output logic [NUM_OUT*CODE_W+3:0]   diag_q,
    output logic [NUM_OUT*CODE_W+3:0]   rd_data
);

    localparam int FIELD_W  = NUM_OUT * CODE_W;
    localparam int STICKY_W = FIELD_W + 3;
    localparam int REG_W    = STICKY_W + 1;

    clr_kind_e           kind;
    logic [STICKY_W-1:0] evt_n;
    logic [STICKY_W-1:0] stored;
    logic [FIELD_W-1:0]  field_vis;

    assign evt_n = {~ot_evt, ~cur_red_evt, ~cur_lim_evt, ch_code};

    diag_clear_ctrl u_clr (
        .pin_di    (pin_di),
        .pin_en    (pin_en),
        .spi_entry (spi_entry),
        .rd_commit (rd_commit),
        .kind      (kind)
    );

    diag_sticky_bank #(.W(STICKY_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .rd_start (rd_start),
        .evt_n    (evt_n),
        .stored_q (stored)
    );

    assign field_vis = uv ? '0 : stored[FIELD_W-1:0];
    assign diag_q    = {run_state(pin_di, pin_en), stored[STICKY_W-1:FIELD_W], field_vis};

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '1;
        else if (rd_start)
            rd_data <= diag_q;
    end

    // R7
    uv_snap_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_start && uv) |=> rd_data[FIELD_W-1:0] == '0);

    // R6 R9
    run_snap_chk: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> rd_data[REG_W-1] == $past(pin_en && !pin_di));

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_start |=> $stable(rd_data));

    // R8
    spi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_entry && pin_en && !pin_di) |=> &stored);

endmodule

// File: tb/test_diag_fault_reg.sv
module test_diag_fault_reg;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] t_code;
    logic       t_lim, t_red, t_ot, t_di, t_en, t_uv, t_spi, t_rs, t_cm;
    logic [7:0] diag_q, rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [6:0] m_st, m_post;
    logic       m_pend;
    logic [7:0] m_snap;

    always #4 clk = ~clk;

    diag_fault_reg i_diag_fault_reg (
        .clk(clk), .rst(rst), .ch_code(t_code),
        .cur_lim_evt(t_lim), .cur_red_evt(t_red), .ot_evt(t_ot),
        .pin_di(t_di), .pin_en(t_en), .uv(t_uv), .spi_entry(t_spi),
        .rd_start(t_rs), .rd_commit(t_cm),
        .diag_q(diag_q), .rd_data(rd_data)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] vis();
        return {t_en & ~t_di, m_st[6:4], t_uv ? 4'h0 : m_st[3:0]};
    endfunction

    task automatic idle();
        t_code = 4'hF; t_lim = 0; t_red = 0; t_ot = 0;
        t_di = 0; t_en = 1; t_uv = 0; t_spi = 0; t_rs = 0; t_cm = 0;
    endtask

    task automatic step(input string tag);
        logic [6:0] ev;
        ev = {~t_ot, ~t_red, ~t_lim, t_code};
        if (t_rs) m_snap = vis();
        if (t_di || !t_en || t_spi) begin
            m_st = '1; m_post = '1; m_pend = 0;
        end else if (t_cm) begin
            m_st = ((m_pend && !t_rs) ? m_post : 7'h7F) & ev;
            m_post = '1; m_pend = 0;
        end else begin
            m_st = m_st & ev;
            if (t_rs) begin m_post = ev; m_pend = 1; end
            else if (m_pend) m_post = m_post & ev;
        end
        @(posedge clk); @(negedge clk);
        chk(diag_q, vis(), tag);
        chk(rd_data, m_snap, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        rst = 1;
        m_st = '1; m_post = '1; m_pend = 0; m_snap = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        chk(diag_q, 8'hFF, "R1 diag_q");
        chk(rd_data, 8'hFF, "R1 rd_data");

        // R3 overtemperature sticky
        t_ot = 1; step("R3"); chk(diag_q, 8'hBF, "R3 ot");
        idle(); step("R3"); chk(diag_q, 8'hBF, "R3 hold");
        // R2 positions
        t_red = 1; step("R2"); chk(diag_q, 8'h9F, "R2 red");
        idle(); t_lim = 1; step("R2"); chk(diag_q, 8'h8F, "R2 lim");
        // R4 code merge
        idle(); t_code = 4'b1101; step("R4"); chk(diag_q, 8'h8D, "R4 out1 01");
        t_code = 4'b1110; step("R4"); chk(diag_q, 8'h8C, "R4 merge 00");
        t_code = 4'b0111; step("R4"); chk(diag_q, 8'h84, "R4 out2 01");
        // R7 undervoltage mask and restore
        idle(); t_uv = 1; step("R7"); chk(diag_q, 8'h80, "R7 mask");
        idle(); step("R7"); chk(diag_q, 8'h84, "R7 restore");
        // R9 snapshot, R10 commit keeps post-snapshot faults
        t_rs = 1; step("R9"); chk(rd_data, 8'h84, "R9 snap");
        idle(); t_code = 4'b1011; step("R10");
        idle(); t_cm = 1; step("R10"); chk(diag_q, 8'hFB, "R10 keep");
        chk(rd_data, 8'h84, "R9 hold");
        idle(); t_cm = 1; step("R10"); chk(diag_q, 8'hFF, "R10 no pend");
        // R8 serial re-entry
        idle(); t_ot = 1; step("R8");
        idle(); t_spi = 1; step("R8"); chk(diag_q, 8'hFF, "R8 clear");
        t_ot = 1; step("R11"); chk(diag_q, 8'hFF, "R11 spi drop");
        // R5 R6 pin clears
        idle(); t_lim = 1; step("R5"); chk(diag_q, 8'hEF, "R5 pre");
        idle(); t_di = 1; t_ot = 1; step("R5"); chk(diag_q, 8'h7F, "R5 di");
        idle(); t_en = 0; step("R6"); chk(diag_q, 8'h7F, "R6 en low");
        t_di = 1; step("R6"); chk(diag_q, 8'h7F, "R6 both");
        idle(); step("R6"); chk(diag_q, 8'hFF, "R6 run");
        // R11 pin clear over commit and spi
        t_di = 1; t_cm = 1; t_spi = 1; t_ot = 1; step("R11"); chk(diag_q, 8'h7F, "R11 prio");
        // R7 snapshot under undervoltage
        idle(); t_code = 4'b1010; step("R7"); chk(diag_q, 8'hFA, "R7 pre");
        idle(); t_uv = 1; t_rs = 1; step("R7"); chk(rd_data, 8'hF0, "R7 snap");
        idle(); step("R7"); chk(diag_q, 8'hFA, "R7 back");

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            t_code = 4'hF;
            for (int b = 0; b < 4; b++)
                if ($urandom_range(99) < 4) t_code[b] = 1'b0;
            t_lim = ($urandom_range(99) < 4);
            t_red = ($urandom_range(99) < 4);
            t_ot  = ($urandom_range(99) < 4);
            t_di  = ($urandom_range(99) < 3);
            t_en  = !($urandom_range(99) < 3);
            if ($urandom_range(99) < 5) t_uv = ~t_uv;
            t_spi = ($urandom_range(99) < 2);
            t_rs  = ($urandom_range(99) < 6);
            t_cm  = ($urandom_range(99) < 6);
            step("R10 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule